// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers service requests from up to 32 peripheral sources and presents them to a processor as one IRQ line. Software arms individual sources through a pair of set and clear command registers that act on a shared enable mask. Each source owns a programmable vector word. When an armed source asks for service, the controller captures that source's number and its vector in one clock edge and raises IRQ.

The processor's handler reads the vector register, which drops IRQ, and then reads the status register, which hands back the captured source number and zeroes it. While IRQ stays high and the vector has not been fetched, no later request can overwrite the captured pair. Sources are level requests sampled every cycle. If several armed sources ask together, the lowest-numbered one is taken. Nothing is queued: a request that arrives while its enable bit is off is simply lost.

Register access is a single-cycle word bus. Read data is combinational from the current state. Read side effects take place at the clock edge that ends the access.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the enable mask, the status register, the vector register and all source vector words read 0, and `irq_o` is low.
- R2: A write to the enable-set register (word address 35) ORs the written bits into the enable mask. The mask reads back at word address 34, with bit n standing for source n.
- R3: A write to the enable-clear register (word address 36) clears each mask bit that is 1 in the written data and leaves the other bits unchanged.
- R4: When an enabled source requests service while `irq_o` is low, the same clock edge does three things: the status register (word address 32) is loaded with the source number, the vector register (word address 33) is loaded with that source's vector word, and `irq_o` is raised.
- R5: A read of the vector register while `irq_o` is high lowers `irq_o` at the clock edge that ends the read.
- R6: A read of the status register returns its current value and clears the register to 0 at the edge that ends the read.
- R7: Writes to the vector register are ignored. A write to the end-of-interrupt register (word address 37) leaves the mask, status and vector registers unchanged.
- R8: A request from a source whose enable bit is clear is ignored and is not remembered, even if that bit is set later.
- R9: When several enabled sources request service in the same cycle, the lowest-numbered one is latched.
- R10: While `irq_o` is high and the vector register has not been read, a new request does not change the vector or status registers.
- R11: Source vector word n sits at word address n (0 to 31), can be read and written, and is held until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 32 | Level service requests, bit n for source n |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, valid during the access |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is the blocking window. A second request has to arrive after a capture has raised IRQ and before the vector fetch, and it has to be a lower-numbered source that would otherwise win. The stimulus fires one source, then pulses a lower one in the next cycle with IRQ still high. It then confirms that the vector and the status still name the first source. A second case is a request lost while its enable bit is clear. The stimulus fires the masked source, re-arms it only after the request has dropped, and checks that IRQ stays low. Every source, and every pair of sources fired together, is swept, with each expected vector computed from its source number.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW = 6;
  // control word addresses sit above the 32 source vector words
  localparam logic [REG_AW-1:0] A_STAT  = 6'd32;
  localparam logic [REG_AW-1:0] A_VEC   = 6'd33;
  localparam logic [REG_AW-1:0] A_MASK  = 6'd34;
  localparam logic [REG_AW-1:0] A_ENSET = 6'd35;
  localparam logic [REG_AW-1:0] A_ENCLR = 6'd36;
  localparam logic [REG_AW-1:0] A_EOI   = 6'd37;
endpackage

// File: rtl/vic_pick.sv
module vic_pick #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  function automatic logic [N-1:0] isolate_low(logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  function automatic logic [IW-1:0] onehot_to_idx(logic [N-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (oh[i]) r = r | IW'(i);
    return r;
  endfunction

  assign any = |req;
  assign idx = onehot_to_idx(isolate_low(req));
endmodule

// File: rtl/vic_mask.sv
module vic_mask #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] bits,
  output logic [N-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_we) mask_q <= mask_q | bits;
    else if (clr_we) mask_q <= mask_q & ~bits;
  end
endmodule

// File: rtl/vic_vec_bank.sv
module vic_vec_bank #(
  parameter int N  = 32,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] vec_o [N]
);
  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              vec_o[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))      vec_o[g] <= wdata;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  // named events for the checker
  logic               rd_stb, wr_stb;
  logic               vec_rd, stat_rd;
  logic               set_wr, clr_wr;
  logic               svec_hit, svec_wr;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pending;
  logic               pend_any;
  logic [IDX_W-1:0]   sel_idx;
  logic               fire;
  logic [DATA_W-1:0]  stat_q, vec_q;
  logic               irq_q;
  logic [DATA_W-1:0]  bank [NUM_SRC];

  assign rd_stb   = bus_sel & ~bus_we;
  assign wr_stb   = bus_sel &  bus_we;
  assign vec_rd   = rd_stb & (bus_addr == A_VEC);
  assign stat_rd  = rd_stb & (bus_addr == A_STAT);
  assign set_wr   = wr_stb & (bus_addr == A_ENSET);
  assign clr_wr   = wr_stb & (bus_addr == A_ENCLR);
  assign svec_hit = (bus_addr < REG_AW'(NUM_SRC));
  assign svec_wr  = wr_stb & svec_hit;

  vic_mask #(.N(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (set_wr),
    .clr_we (clr_wr),
    .bits   (bus_wdata[NUM_SRC-1:0]),
    .mask_q (mask_q)
  );

  vic_vec_bank #(.N(NUM_SRC), .DW(DATA_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (svec_wr),
    .wr_idx (bus_addr[IDX_W-1:0]),
    .wdata  (bus_wdata),
    .vec_o  (bank)
  );

  assign pending = src_req & mask_q;

  vic_pick #(.N(NUM_SRC)) u_pick (
    .req (pending),
    .any (pend_any),
    .idx (sel_idx)
  );

  // capture only when no vector fetch is outstanding
  assign fire = pend_any & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      vec_q  <= '0;
      irq_q  <= 1'b0;
    end else if (fire) begin
      stat_q <= DATA_W'(sel_idx);
      vec_q  <= bank[sel_idx];
      irq_q  <= 1'b1;
    end else begin
      if (vec_rd)  irq_q  <= 1'b0;
      if (stat_rd) stat_q <= '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (svec_hit) bus_rdata = bank[bus_addr[IDX_W-1:0]];
    else begin
      case (bus_addr)
        A_STAT:  bus_rdata = stat_q;
        A_VEC:   bus_rdata = vec_q;
        A_MASK:  bus_rdata = DATA_W'(mask_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               fire,
  input logic               vec_rd,
  input logic               stat_rd,
  input logic               set_wr,
  input logic               clr_wr,
  input logic [NUM_SRC-1:0] src_req,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [IDX_W-1:0]   sel_idx,
  input logic [DATA_W-1:0]  stat_q,
  input logic [DATA_W-1:0]  vec_q,
  input logic [DATA_W-1:0]  wdata
);
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq_o && stat_q == DATA_W'($past(sel_idx)));

  p_vec_read_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_o) |=> !irq_o);

  p_stat_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !fire) |=> stat_q == '0);

  p_enable_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (mask_q & $past(wdata[NUM_SRC-1:0])) == '0);

  p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (mask_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0]));

  p_only_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> src_req[sel_idx] && mask_q[sel_idx]);

  p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((src_req & mask_q) & ((NUM_SRC'(1) << sel_idx) - NUM_SRC'(1))) == '0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !vec_rd) |=> irq_o && $stable(vec_q));
endmodule

bind irq_vector_ctrl vic_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_o   (irq_o),
  .fire    (fire),
  .vec_rd  (vec_rd),
  .stat_rd (stat_rd),
  .set_wr  (set_wr),
  .clr_wr  (clr_wr),
  .src_req (src_req),
  .mask_q  (mask_q),
  .sel_idx (sel_idx),
  .stat_q  (stat_q),
  .vec_q   (vec_q),
  .wdata   (bus_wdata)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int N = 32;
  localparam logic [5:0] A_STAT = 6'd32, A_VEC = 6'd33, A_MASK = 6'd34,
                         A_ENSET = 6'd35, A_ENCLR = 6'd36, A_EOI = 6'd37;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] vexp(int i);
    return 32'hC0DE_0000 + 32'(i * i * 7 + 3);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse(logic [31:0] p);
    src_req = p;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_STAT, d); chk("R1 stat", d, 0);
    rd(A_VEC, d);  chk("R1 vec", d, 0);
    rd(6'd7, d);   chk("R1 svec", d, 0);

    // R11 program vector words
    for (int i = 0; i < N; i++) wr(6'(i), vexp(i));
    for (int i = 0; i < N; i++) begin rd(6'(i), d); chk("R11 svec", d, vexp(i)); end

    // R2 / R3 mask set and clear
    wr(A_ENSET, 32'h0000_00F0); rd(A_MASK, d); chk("R2 set", d, 32'h0000_00F0);
    wr(A_ENSET, 32'h0F00_0000); rd(A_MASK, d); chk("R2 or", d, 32'h0F00_00F0);
    wr(A_ENCLR, 32'h0100_0030); rd(A_MASK, d); chk("R3 clr", d, 32'h0E00_00C0);
    wr(A_ENSET, 32'hFFFF_FFFF); rd(A_MASK, d); chk("R2 all", d, 32'hFFFF_FFFF);

    // R4/R5/R6 every single source
    for (int i = 0; i < N; i++) begin
      pulse(32'd1 << i);
      chk("R4 irq", {31'd0, irq_o}, 32'd1);
      rd(A_VEC, d);  chk("R4 vec", d, vexp(i));
      chk("R5 irq low", {31'd0, irq_o}, 32'd0);
      rd(A_STAT, d); chk("R4 stat", d, 32'(i));
      rd(A_STAT, d); chk("R6 cleared", d, 0);
    end

    // R9 all pairs fired together
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        pulse((32'd1 << i) | (32'd1 << j));
        rd(A_VEC, d);  chk("R9 vec", d, vexp(i));
        rd(A_STAT, d); chk("R9 stat", d, 32'(i));
      end
    pulse(32'hFFFF_FFFF);
    rd(A_VEC, d); chk("R9 all", d, vexp(0));
    rd(A_STAT, d);

    // R10 blocking window, lower source arrives late
    pulse(32'd1 << 9);
    pulse(32'd1 << 2);
    chk("R10 irq", {31'd0, irq_o}, 32'd1);
    // R7 writes to vector and EOI change nothing
    wr(A_VEC, 32'hDEAD_BEEF);
    wr(A_EOI, 32'hFFFF_FFFF);
    rd(A_MASK, d); chk("R7 mask", d, 32'hFFFF_FFFF);
    chk("R7 irq", {31'd0, irq_o}, 32'd1);
    rd(A_VEC, d);  chk("R10 vec", d, vexp(9));
    rd(A_STAT, d); chk("R10 stat", d, 32'd9);

    // R8 disabled request is dropped
    wr(A_ENCLR, 32'd1 << 5);
    pulse(32'd1 << 5);
    chk("R8 no irq", {31'd0, irq_o}, 32'd0);
    wr(A_ENSET, 32'd1 << 5);
    @(negedge clk);
    chk("R8 not remembered", {31'd0, irq_o}, 32'd0);
    rd(A_VEC, d); chk("R8 vec", d, vexp(9));

    finish_up();
  end
endmodule